// File: doc/BRIEF.md
# Word-Interleaved Banked Memory

This block is a memory spread over a set of independent banks, with the word address split so that neighbouring words live in neighbouring banks. Every access, read or write, holds its bank for a fixed number of cycles. Accesses to different banks overlap freely, so a stream of requests can be taken at one per cycle while earlier ones are still in progress.

A requester drives one valid/ready port carrying an address, a write flag and write data. Ready drops only while the request targets a bank that is still working on an earlier access. Reads return their data on a response port in the same order the reads were taken. Writes return nothing.

Throughput therefore depends on the access pattern. A stride that visits more banks than the latency in cycles never waits. A stride that comes back to a bank too soon pays the rest of that bank's busy time on every return.

Top module: `interleaved_mem`

## Requirements
- R1: A word address `a` selects bank `a % NUM_BANKS` and row `a / NUM_BANKS` inside that bank. Every word of the address space is a separate storage location.
- R2: A request accepted in cycle c (valid and ready high at the edge ending c) keeps its bank busy through cycle c+LATENCY. While a request targets a busy bank, `req_ready` is low. The bank accepts again from cycle c+LATENCY+1.
- R3: `req_ready` is high whenever the targeted bank is idle, so requests to idle banks are taken in consecutive cycles. A unit-stride stream never stalls when NUM_BANKS > LATENCY.
- R4: The data of a read accepted in cycle c is shown on `rsp_rdata`, with `rsp_valid` high, in cycle c+LATENCY only, for exactly one cycle.
- R5: Read responses appear in the order the reads were accepted, at most one per cycle, and every accepted read produces exactly one response.
- R6: A write stores `req_wdata` at its word and produces no response. A later read of that word returns the stored value.
- R7: During and right after reset all banks are idle: `req_ready` is high and `rsp_valid` is low.
- R8: A stream whose stride is a multiple of NUM_BANKS hits one bank. Each request after the first waits exactly LATENCY stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Targeted bank can take the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The bench uses the default build: sixteen banks, a latency of eleven cycles, an 8-bit word address and 32-bit data. It fills all 256 words and reads them back.

Because sixteen exceeds eleven, unit stride and stride three must run without a stall. Strides of two, eight and sixteen revisit a bank before it frees. They give stall totals of 12, 50 and 77, which come from the busy window alone.

A lone read measures the response cycle. A lone write checks that no response appears and that the overwritten word reads back.

// File: rtl/imb_pkg.sv
package imb_pkg;

  // Bank that holds a word: low part of the word address.
  function automatic int unsigned bank_of(input int unsigned addr, input int unsigned nbanks);
    return addr % nbanks;
  endfunction

  // Row inside the bank: remaining high part of the word address.
  function automatic int unsigned row_of(input int unsigned addr, input int unsigned nbanks);
    return addr / nbanks;
  endfunction

endpackage

// File: rtl/imb_bank.sv
module imb_bank #(
  parameter int DATA_W  = 32,
  parameter int ROW_W   = 4,
  parameter int LATENCY = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              acc_wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS  = 2 ** ROW_W;
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0]  cnt;
  logic              rd_pend;
  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rd_pend <= 1'b0;
    end else if (acc) begin
      cnt     <= CNT_W'(LATENCY);
      rd_pend <= !acc_wr;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) rd_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      if (acc_wr) mem[row] <= wdata;
      else        rdata_q  <= mem[row];
    end
  end

  assign busy  = (cnt != '0);
  assign done  = rd_pend && (cnt == CNT_W'(1));
  assign rdata = rdata_q;

  // R2: an access is only taken by an idle bank
  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    acc |-> !busy);
  // R2: accepting loads the full busy window
  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> (cnt == CNT_W'(LATENCY)));
  // R2: the busy window counts down one per cycle
  assert_countdown_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !acc) |=> (cnt == $past(cnt) - 1'b1));
  // R6: a write leaves no pending response
  assert_write_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && acc_wr) |=> !rd_pend);

endmodule

// File: rtl/imb_rsp_sel.sv
module imb_rsp_sel #(
  parameter int NUM_BANKS = 16,
  parameter int DATA_W    = 32
) (
  input  logic [NUM_BANKS-1:0]             done,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] data,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_rdata
);
  always_comb begin
    rsp_rdata = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (done[i]) rsp_rdata = rsp_rdata | data[i];
    end
  end

  assign rsp_valid = |done;
endmodule

// File: rtl/interleaved_mem.sv
module interleaved_mem #(
  parameter int NUM_BANKS = 16,
  parameter int LATENCY   = 11,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;

  logic [BANK_W-1:0]               bank_idx;
  logic [ROW_W-1:0]                row_idx;
  logic [NUM_BANKS-1:0]            bank_busy;
  logic [NUM_BANKS-1:0]            bank_done;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic                            req_fire;

  assign bank_idx  = BANK_W'(imb_pkg::bank_of(32'(req_addr), NUM_BANKS));
  assign row_idx   = ROW_W'(imb_pkg::row_of(32'(req_addr), NUM_BANKS));
  assign req_ready = !bank_busy[bank_idx];
  assign req_fire  = req_valid && req_ready;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic acc_g;
    assign acc_g = req_fire && (bank_idx == BANK_W'(g));
    imb_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .LATENCY(LATENCY)) i_bank (
      .clk   (clk),
      .rst   (rst),
      .acc   (acc_g),
      .acc_wr(req_write),
      .row   (row_idx),
      .wdata (req_wdata),
      .busy  (bank_busy[g]),
      .done  (bank_done[g]),
      .rdata (bank_rdata[g])
    );
  end

  imb_rsp_sel #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) i_rsp_sel (
    .done     (bank_done),
    .data     (bank_rdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  // R5: at most one bank completes a read in any cycle
  assert_single_completion_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_done));
  // R4: a response is shown for one cycle unless a different bank follows
  assert_rsp_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $stable(bank_done)) |-> (bank_done == '0) || !rsp_valid);
  // R3: an idle target bank always takes the request
  assert_idle_takes_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (bank_busy == '0)) |-> req_ready);

endmodule

// File: tb/test_interleaved_mem.sv
`timescale 1ns/1ps
module test_interleaved_mem;
  localparam int NB  = 16;
  localparam int LAT = 11;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int WORDS = 2 ** AW;

  // start, stride, count, expected stalls
  localparam int unsigned TBL [5][4] = '{
    '{0, 1, 32, 0},   // R3 unit stride
    '{1, 3, 16, 0},   // R3 odd stride visits all banks
    '{0, 2, 32, 12},  // R2 eight banks, 4 stalls per revisit group
    '{7, 8, 12, 50},  // R2 two banks, 10 stalls per revisit pair
    '{5, 16, 8, 77}   // R8 one bank, LAT stalls each
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic [DW-1:0] model_mem [WORDS];
  logic [DW-1:0] exp_q [1024];
  int wr_ptr = 0, rd_ptr = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  interleaved_mem #(.NUM_BANKS(NB), .LATENCY(LAT), .ADDR_W(AW), .DATA_W(DW)) i_interleaved_mem (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R5/R6 response monitor: in order, nothing unexpected
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (rd_ptr == wr_ptr) begin
        check(0, "R6 unexpected response", 1, 0);
      end else begin
        checks++;
        if (rsp_rdata !== exp_q[rd_ptr]) begin
          errors++;
          $display("FAIL R5 response %0d: actual %h expected %h", rd_ptr, rsp_rdata, exp_q[rd_ptr]);
        end
        rd_ptr++;
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int unsigned a);
    return DW'(a) * 32'h9E3779B1 + 32'd1;
  endfunction

  task automatic issue(input int unsigned a, input bit wr, input logic [DW-1:0] d, inout int stalls);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
    if (wr) model_mem[a % WORDS] = d;
    else begin exp_q[wr_ptr] = model_mem[a % WORDS]; wr_ptr++; end
    #1 req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int st, n;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(req_ready === 1'b1, "R7 ready in reset", int'(req_ready), 1);
    check(rsp_valid === 1'b0, "R7 rsp_valid in reset", int'(rsp_valid), 0);
    rst = 0;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R7 after reset", int'(req_ready), 1);

    // R1/R6 fill every word, unit stride, no stalls
    st = 0;
    for (int a = 0; a < WORDS; a++) issue(a, 1'b1, pat(a), st);
    check(st == 0, "R3 fill stalls", st, 0);
    idle(2 * LAT);

    // table of stride streams (R1 data by bank/row, R2/R3/R8 stall counts)
    for (int v = 0; v < 5; v++) begin
      st = 0;
      for (int k = 0; k < int'(TBL[v][2]); k++)
        issue(TBL[v][0] + TBL[v][1] * k, 1'b0, '0, st);
      check(st == int'(TBL[v][3]), $sformatf("R2 R3 R8 stride %0d stalls", TBL[v][1]), st, int'(TBL[v][3]));
      idle(2 * LAT);
    end

    // R4 latency of a lone read and one-cycle response
    st = 0;
    issue(40, 1'b0, '0, st);
    n = 0;
    forever begin
      @(negedge clk); n++;
      if (rsp_valid || n > 3 * LAT) break;
    end
    check(n == LAT, "R4 response cycle", n, LAT);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R4 single-cycle response", int'(rsp_valid), 0);
    idle(2 * LAT);

    // R6 lone write: no response in its window, then read back new value
    st = 0;
    issue(40, 1'b1, 32'hCAFE_0040, st);
    n = 0;
    for (int c = 0; c < 2 * LAT; c++) begin
      @(negedge clk);
      if (rsp_valid) n++;
    end
    check(n == 0, "R6 write response count", n, 0);
    issue(40, 1'b0, '0, st);
    idle(2 * LAT);

    // R2 directed: same bank back to back waits LAT, other bank does not
    st = 0;
    issue(3, 1'b0, '0, st);
    issue(19, 1'b0, '0, st);
    check(st == LAT, "R2 same-bank wait", st, LAT);
    st = 0;
    issue(4, 1'b0, '0, st);
    issue(5, 1'b0, '0, st);
    check(st == 0, "R3 different-bank wait", st, 0);
    idle(2 * LAT);

    // R5 every read answered
    check(rd_ptr == wr_ptr, "R5 responses drained", rd_ptr, wr_ptr);
    finish_up();
  end
endmodule